// File: doc/BRIEF.md
# Non-Posted Credit Gate

The gate merges two request classes onto one downstream stream. Posted requests and non-posted requests arrive on separate valid/ready inputs. Each class waits in its own small first-in first-out queue, and every entry is one whole request descriptor. A non-posted request may leave only while the gate holds at least one unit of credit. Posted requests never wait for credit, so a stalled non-posted head cannot block them.

The consumer grants credit with a 2-bit code on every cycle. The grant passes through a parameterized pipeline before it reaches the count. The count is capped at a maximum, and it is exported so the consumer can see how much room it has granted. The count is cleared by reset and whenever the link-up input is low. When both classes are ready to send, the gate alternates between them. This keeps posted traffic from starving non-posted traffic that has credit.

Top module: `np_credit_gate`

## Requirements
- R1: The credit code `credit_req` is sampled on every clock edge. Code 2'b00 adds 0, 2'b01 adds 1, and 2'b10 or 2'b11 adds 2. With the default single pipeline stage, a code present before edge k changes `credit_count` at edge k+1.
- R2: Each accepted non-posted transfer lowers the count by one. A transfer is accepted when `out_valid`, `out_ready` and `out_is_np` are all high. If credit arrives and a transfer is accepted in the same cycle, the net change is applied once.
- R3: After the net change, the count is clamped to the range 0 to 32. It is shown on the 6-bit `credit_count` output.
- R4: `out_valid` is never high with `out_is_np` high while `credit_count` is zero.
- R5: Posted requests are delivered while the count is zero and a non-posted request is waiting.
- R6: While `link_up` is low, the count and any credit in the pipeline are cleared at every edge. The count then reads zero from the following cycle. Credit codes presented while the link is down are lost.
- R7: After reset, `credit_count` is 0, `out_valid` is 0, and both input ready signals are 1.
- R8: When both classes are eligible, consecutive accepted transfers alternate between posted and non-posted.
- R9: While `link_up` stays high, an offer that is not accepted keeps `out_valid`, `out_data` and `out_is_np` unchanged in the next cycle.
- R10: Each class is delivered in arrival order. An input ready signal drops once its queue holds DEPTH entries; the default DEPTH is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link state; low clears the credit count |
| pst_in_valid | input | 1 | Posted request valid |
| pst_in_ready | output | 1 | Posted queue can accept |
| pst_in_data | input | DW (32) | Posted request descriptor |
| npr_in_valid | input | 1 | Non-posted request valid |
| npr_in_ready | output | 1 | Non-posted queue can accept |
| npr_in_data | input | DW (32) | Non-posted request descriptor |
| out_valid | output | 1 | Downstream request valid |
| out_ready | input | 1 | Downstream can accept |
| out_data | output | DW (32) | Downstream request descriptor |
| out_is_np | output | 1 | Current output is non-posted |
| credit_req | input | 2 | Per-cycle credit grant code |
| credit_count | output | CW (6) | Current non-posted credit |

## Verification
The bench tries four kinds of input pattern:

- **Zero credit with both classes queued.** This shows that the credit gate holds back only non-posted requests.
- **Long runs of the 2'b11 code with no consumption.** These separate a correct clamp at 32 from a wrapping count.
- **Both queues full under a generous grant.** This exposes the alternation order, and it distinguishes a fair arbiter from a fixed priority.
- **Random mixes of grant codes, back-pressure and short link drops.** These are compared cycle by cycle against a model of the count. They separate the correct latency, the net-then-clamp rule and the link clear from off-by-one timing or a wrong decrement.

// File: rtl/np_gate_pkg.sv
package np_gate_pkg;

   typedef enum logic {
      SRC_PST = 1'b0,
      SRC_NP  = 1'b1
   } src_e;

   // map a 2-bit grant code to the amount of credit it adds
   function automatic logic [1:0] grant_amount(input logic [1:0] code);
      logic [1:0] amt;
      unique case (code)
         2'b00:   amt = 2'd0;
         2'b01:   amt = 2'd1;
         default: amt = 2'd2;
      endcase
      return amt;
   endfunction

endpackage

// File: rtl/npg_fifo.sv
module npg_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic          full,
   output logic          empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
   localparam logic [AW:0]   FULL_CNT = (AW + 1)'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("npg_fifo: DEPTH must be at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [AW:0]   fill;

   logic do_push, do_pop;
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   assign full  = (fill == FULL_CNT);
   assign empty = (fill == '0);
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

endmodule

// File: rtl/npg_credit.sv
module npg_credit
   import np_gate_pkg::*;
#(
   parameter int CNT_MAX = 32,
   parameter int PIPE    = 1,
   parameter int CW      = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          link_up,
   input  logic [1:0]    grant_code,
   input  logic          take,
   output logic [CW-1:0] count
);
   localparam logic [CW:0] MAX_V = (CW + 1)'(CNT_MAX);

   if (CNT_MAX < 1) begin : g_bad_max
      $error("npg_credit: CNT_MAX must be positive");
   end
   if (PIPE < 0) begin : g_bad_pipe
      $error("npg_credit: PIPE must not be negative");
   end
   if (CW < $clog2(CNT_MAX + 1)) begin : g_bad_cw
      $error("npg_credit: CW too narrow for CNT_MAX");
   end

   logic [1:0] add_now;
   logic [1:0] add_late;
   assign add_now = grant_amount(grant_code);

   if (PIPE == 0) begin : g_direct
      assign add_late = link_up ? add_now : 2'd0;
   end else begin : g_staged
      logic [1:0] stage [PIPE];
      always_ff @(posedge clk) begin
         if (!rst_n || !link_up) begin
            for (int i = 0; i < PIPE; i++) stage[i] <= 2'd0;
         end else begin
            stage[0] <= add_now;
            for (int i = 1; i < PIPE; i++) stage[i] <= stage[i-1];
         end
      end
      assign add_late = stage[PIPE-1];
   end

   logic [CW-1:0] cnt_q;
   logic [CW:0]   sum;

   always_comb begin
      sum = {1'b0, cnt_q} + {{(CW-1){1'b0}}, add_late};
      if (take && (sum != '0)) sum = sum - 1'b1;
      if (sum > MAX_V) sum = MAX_V;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !link_up) cnt_q <= '0;
      else                    cnt_q <= sum[CW-1:0];
   end

   assign count = cnt_q;

endmodule

// File: rtl/npg_arb.sv
module npg_arb
   import np_gate_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic link_up,
   input  logic pst_elig,
   input  logic np_elig,
   input  logic out_ready,
   output logic out_valid,
   output src_e sel
);
   logic lock_q;
   src_e lock_src_q;
   logic last_np_q;
   src_e pick;

   always_comb begin
      if (pst_elig && np_elig) pick = last_np_q ? SRC_PST : SRC_NP;
      else if (np_elig)        pick = SRC_NP;
      else                     pick = SRC_PST;
   end

   assign sel       = lock_q ? lock_src_q : pick;
   assign out_valid = lock_q || pst_elig || np_elig;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q     <= 1'b0;
         lock_src_q <= SRC_PST;
         last_np_q  <= 1'b0;
      end else begin
         if (!link_up) begin
            lock_q <= 1'b0;
         end else if (out_valid && !out_ready) begin
            lock_q     <= 1'b1;
            lock_src_q <= sel;
         end else begin
            lock_q <= 1'b0;
         end
         if (out_valid && out_ready) last_np_q <= (sel == SRC_NP);
      end
   end

endmodule

// File: rtl/np_credit_gate.sv
module np_credit_gate
   import np_gate_pkg::*;
#(
   parameter int DW          = 32,
   parameter int DEPTH       = 4,
   parameter int CNT_MAX     = 32,
   parameter int CREDIT_PIPE = 1,
   parameter int CW          = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          link_up,
   input  logic          pst_in_valid,
   output logic          pst_in_ready,
   input  logic [DW-1:0] pst_in_data,
   input  logic          npr_in_valid,
   output logic          npr_in_ready,
   input  logic [DW-1:0] npr_in_data,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_data,
   output logic          out_is_np,
   input  logic [1:0]    credit_req,
   output logic [CW-1:0] credit_count
);
   if (DW < 1) begin : g_bad_dw
      $error("np_credit_gate: DW must be positive");
   end

   logic          pst_full, pst_empty, np_full, np_empty;
   logic [DW-1:0] pst_head, np_head;
   logic          pst_pop, np_pop;
   logic          arb_valid;
   src_e          sel;

   assign pst_in_ready = !pst_full;
   assign npr_in_ready = !np_full;

   npg_fifo #(.DW(DW), .DEPTH(DEPTH)) u_pst_q (
      .clk(clk), .rst_n(rst_n),
      .push(pst_in_valid), .din(pst_in_data),
      .pop(pst_pop), .dout(pst_head),
      .full(pst_full), .empty(pst_empty)
   );

   npg_fifo #(.DW(DW), .DEPTH(DEPTH)) u_np_q (
      .clk(clk), .rst_n(rst_n),
      .push(npr_in_valid), .din(npr_in_data),
      .pop(np_pop), .dout(np_head),
      .full(np_full), .empty(np_empty)
   );

   npg_credit #(.CNT_MAX(CNT_MAX), .PIPE(CREDIT_PIPE), .CW(CW)) u_credit (
      .clk(clk), .rst_n(rst_n), .link_up(link_up),
      .grant_code(credit_req), .take(np_pop),
      .count(credit_count)
   );

   npg_arb u_arb (
      .clk(clk), .rst_n(rst_n), .link_up(link_up),
      .pst_elig(!pst_empty),
      .np_elig(!np_empty && (credit_count != '0)),
      .out_ready(out_ready),
      .out_valid(arb_valid), .sel(sel)
   );

   assign out_valid = arb_valid;
   assign out_is_np = (sel == SRC_NP);
   assign out_data  = out_is_np ? np_head : pst_head;
   assign pst_pop   = arb_valid && out_ready && !out_is_np;
   assign np_pop    = arb_valid && out_ready && out_is_np;

endmodule

// File: rtl/npg_checker.sv
module npg_checker #(
   parameter int DW      = 32,
   parameter int CNT_MAX = 32,
   parameter int CW      = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          link_up,
   input logic [1:0]    credit_req,
   input logic [CW-1:0] credit_count,
   input logic          out_valid,
   input logic          out_ready,
   input logic [DW-1:0] out_data,
   input logic          out_is_np
);
   a_r3_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
      credit_count <= CW'(CNT_MAX));

   a_r1_rise_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, credit_count} <= {1'b0, $past(credit_count)} + (CW + 1)'(2)));

   a_r2_take_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_is_np && link_up && credit_req == 2'b00)
      |=> ({1'b0, credit_count} <= {1'b0, $past(credit_count)} + (CW + 1)'(2)));

   a_r4_no_np_without_credit: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_is_np) |-> (credit_count != '0));

   a_r6_link_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up |=> (credit_count == '0));

   a_r9_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && link_up)
      |=> (out_valid && $stable(out_data) && $stable(out_is_np)));

endmodule

bind np_credit_gate npg_checker #(.DW(DW), .CNT_MAX(CNT_MAX), .CW(CW)) u_npg_chk (
   .clk(clk), .rst_n(rst_n), .link_up(link_up), .credit_req(credit_req),
   .credit_count(credit_count), .out_valid(out_valid), .out_ready(out_ready),
   .out_data(out_data), .out_is_np(out_is_np)
);

// File: tb/np_credit_gate_tb.sv
`timescale 1ns/1ps
module np_credit_gate_tb_top;
   localparam int DW = 32;
   localparam int CW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic link_up = 1'b0;
   logic pst_in_valid = 1'b0, npr_in_valid = 1'b0;
   logic pst_in_ready, npr_in_ready;
   logic [DW-1:0] pst_in_data = '0, npr_in_data = '0;
   logic out_valid, out_is_np;
   logic out_ready = 1'b0;
   logic [DW-1:0] out_data;
   logic [1:0] credit_req = 2'b00;
   logic [CW-1:0] credit_count;

   always #5 clk = ~clk;

   np_credit_gate dut_i (
      .clk(clk), .rst_n(rst_n), .link_up(link_up),
      .pst_in_valid(pst_in_valid), .pst_in_ready(pst_in_ready), .pst_in_data(pst_in_data),
      .npr_in_valid(npr_in_valid), .npr_in_ready(npr_in_ready), .npr_in_data(npr_in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_is_np(out_is_np), .credit_req(credit_req), .credit_count(credit_count)
   );

   int n_checks = 0;
   int n_fail = 0;

   // drive values for the next cycle
   logic d_link = 1'b0, d_pv = 1'b0, d_nv = 1'b0, d_rdy = 1'b0;
   logic [1:0] d_cr = 2'b00;

   // reference model state
   int m_cnt = 0;
   int m_pend = 0;
   logic [DW-1:0] pq [1024];
   logic [DW-1:0] nq [1024];
   int pq_h = 0, pq_t = 0, nq_h = 0, nq_t = 0;
   int id = 1;
   int n_pst_out = 0, n_np_out = 0;
   int hs_n = 0;
   logic hs_last = 1'b0;

   function automatic int grant_of(input logic [1:0] c);
      return (c == 2'b00) ? 0 : (c == 2'b01) ? 1 : 2;
   endfunction

   function automatic int next_count(input int cnt, input int add, input int take);
      int s;
      s = cnt + add - take;
      if (s > 32) s = 32;
      if (s < 0) s = 0;
      return s;
   endfunction

   task automatic check(input logic ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      logic take;
      @(negedge clk);
      check(credit_count == CW'(m_cnt), "R1 R2 R3 credit_count", int'(credit_count), m_cnt);
      link_up      = d_link;
      pst_in_valid = d_pv;
      npr_in_valid = d_nv;
      pst_in_data  = {1'b0, 15'd0, 16'(id)};
      npr_in_data  = {1'b1, 15'd0, 16'(id + 1)};
      out_ready    = d_rdy;
      credit_req   = d_cr;
      #1;
      take = 1'b0;
      if (out_valid && out_ready) begin
         hs_last = out_is_np;
         hs_n++;
         if (out_is_np) begin
            take = 1'b1;
            n_np_out++;
            check(m_cnt > 0, "R4 np sent with zero credit", m_cnt, 1);
            if (nq_h == nq_t) check(1'b0, "R10 np output with empty model queue", 0, 1);
            else begin
               check(out_data == nq[nq_h], "R10 np order", int'(out_data), int'(nq[nq_h]));
               nq_h++;
            end
         end else begin
            n_pst_out++;
            if (pq_h == pq_t) check(1'b0, "R10 posted output with empty model queue", 0, 1);
            else begin
               check(out_data == pq[pq_h], "R10 posted order", int'(out_data), int'(pq[pq_h]));
               pq_h++;
            end
         end
      end
      if (pst_in_valid && pst_in_ready) begin pq[pq_t] = pst_in_data; pq_t++; end
      if (npr_in_valid && npr_in_ready) begin nq[nq_t] = npr_in_data; nq_t++; end
      id += 2;
      if (!link_up) begin
         m_cnt = 0;
         m_pend = 0;
      end else begin
         m_cnt = next_count(m_cnt, m_pend, take ? 1 : 0);
         m_pend = grant_of(credit_req);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [DW-1:0] held;
      logic held_np;
      int rr_bad;
      int hs0;
      logic prev;
      void'($urandom(32'd1234));

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R7 reset state
      check(credit_count == '0, "R7 count after reset", int'(credit_count), 0);
      check(out_valid == 1'b0, "R7 out_valid after reset", int'(out_valid), 0);
      check(pst_in_ready && npr_in_ready, "R7 readys after reset",
            int'({pst_in_ready, npr_in_ready}), 3);

      // R4 / R5: zero credit, posted passes, non-posted held
      d_link = 1'b1; d_rdy = 1'b1; d_cr = 2'b00;
      d_pv = 1'b1; d_nv = 1'b1; step();
      d_nv = 1'b0; step();
      d_pv = 1'b0;
      repeat (8) step();
      check(n_pst_out == 2, "R5 posted delivered at zero credit", n_pst_out, 2);
      check(n_np_out == 0, "R4 np held at zero credit", n_np_out, 0);
      check(out_valid == 1'b0, "R4 no offer at zero credit", int'(out_valid), 0);

      // R1 / R2: one unit of credit releases exactly one request
      d_cr = 2'b01; step();
      d_cr = 2'b00;
      repeat (6) step();
      check(n_np_out == 1, "R2 one np per credit", n_np_out, 1);
      check(credit_count == '0, "R2 count back to zero", int'(credit_count), 0);

      // R3: saturation
      d_rdy = 1'b0; d_cr = 2'b11;
      repeat (22) step();
      check(credit_count == CW'(32), "R3 saturates at 32", int'(credit_count), 32);

      // R10: queue full drops ready
      d_cr = 2'b00; d_pv = 1'b1; d_nv = 1'b1;
      repeat (5) step();
      d_pv = 1'b0; d_nv = 1'b0;
      step();
      check(pst_in_ready == 1'b0, "R10 posted ready low when full", int'(pst_in_ready), 0);
      check(npr_in_ready == 1'b0, "R10 np ready low when full", int'(npr_in_ready), 0);

      // R9: held offer is stable
      held = out_data; held_np = out_is_np;
      repeat (3) step();
      check(out_valid && out_data == held && out_is_np == held_np, "R9 offer stable",
            int'(out_data), int'(held));

      // R8: alternation with both classes eligible
      d_rdy = 1'b1;
      hs0 = hs_n; rr_bad = 0;
      step();
      prev = hs_last;
      repeat (7) begin
         step();
         if (hs_last == prev) rr_bad++;
         prev = hs_last;
      end
      check(hs_n - hs0 == 8, "R8 eight transfers", hs_n - hs0, 8);
      check(rr_bad == 0, "R8 alternation", rr_bad, 0);

      // R6: link drop clears count and discards pending credit
      d_cr = 2'b11; repeat (4) step();
      check(credit_count != '0, "R6 count nonzero before drop", int'(credit_count), 1);
      d_link = 1'b0; repeat (2) step();
      check(credit_count == '0, "R6 count cleared while link down", int'(credit_count), 0);
      d_link = 1'b1; d_cr = 2'b00; repeat (3) step();
      check(credit_count == '0, "R6 no credit survives link drop", int'(credit_count), 0);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = int'($urandom_range(0, 99));
         d_cr = (r < 60) ? 2'b00 : (r < 80) ? 2'b01 : (r < 90) ? 2'b10 : 2'b11;
         d_pv = ($urandom_range(0, 1) == 1);
         d_nv = ($urandom_range(0, 1) == 1);
         d_rdy = ($urandom_range(0, 9) < 7);
         if ($urandom_range(0, 199) == 0) d_link = 1'b0;
         else if (!d_link && $urandom_range(0, 2) == 0) d_link = 1'b1;
         step();
      end

      // drain
      d_link = 1'b1; d_pv = 1'b0; d_nv = 1'b0; d_rdy = 1'b1; d_cr = 2'b11;
      repeat (40) step();
      check(pq_h == pq_t && nq_h == nq_t, "R10 all requests delivered",
            (pq_t - pq_h) + (nq_t - nq_h), 0);

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule